// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block feeds a serial transmitter from memory by following a linked list of buffer descriptors. The host sets a page byte, the pointer of the first descriptor and a stop pointer, then sets the enable bit. The engine reads each descriptor over a byte-wide memory read port and then reads the buffer that the descriptor names. It hands the bytes to the transmitter one at a time, whenever the transmitter asks for data. When a buffer is used up, the engine moves to the next descriptor on its own.

The walk ends when the transmitter asks for data while the current pointer equals the stop pointer. At that point the engine drops its enable bit, sets a sticky completion flag and returns to idle. While a run is in progress, the host can move the stop pointer forward to append buffers it has just filled. An interrupt output reports the flag when interrupts are enabled.

Top module: `txdma_chain`

## Requirements
- R1: After reset the enable bit, interrupt enable, completion flag, all pointers and the page byte are zero, and `mem_req_o` and `tx_ack_o` are low.
- R2: A descriptor sits at the 24-bit address {page byte, 16-bit pointer} and is read byte by byte at offsets 0 to 6. Its fields are little-endian: offsets 0–1 hold the next-descriptor pointer, 2–4 the 24-bit buffer address, and 5–6 the 16-bit byte count. Offset 7 is not read.
- R3: The bytes of each buffer reach `tx_data_o` in address order and across descriptors in chain order. One byte is handed over in each cycle where `tx_ack_o` and `tx_req_i` are both high, and `tx_ack_o` is never high without `tx_req_i`.
- R4: A memory read is a transfer on a cycle with `mem_req_o` and `mem_ready_i` both high, and `mem_rdata_i` is taken in that same cycle. While the request waits for `mem_ready_i`, both the request and its address stay unchanged, unless the enable bit is low.
- R5: When the last byte of a buffer has been read, the current pointer takes the descriptor's link value without any host write. The pointer changes only through that load or through a host write to register 1.
- R6: A descriptor with a byte count of zero sends nothing, and the engine moves straight on to its link.
- R7: While the current pointer equals the stop pointer, no memory read is issued. A cycle with `tx_req_i` high and no byte waiting in the output register ends the run: the enable bit clears and the completion flag sets on the next edge.
- R8: A host write that moves the stop pointer during a run extends the chain. Descriptors up to the new stop pointer are then sent in the same run.
- R9: The completion flag stays set until the host writes 1 to bit 0 of register 4. Writing 0 there leaves the flag unchanged. `irq_o` equals the flag AND the interrupt enable.
- R10: Host writes use `cfg_addr_i`: 0 sets the page byte (`wdata[7:0]`), 1 the current pointer, 2 the stop pointer, and 3 the control register (bit 0 enable, bit 1 interrupt enable). Writing 1 to the enable bit while the current pointer differs from the stop pointer starts a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Host register write strobe |
| cfg_addr_i | input | 3 | Host register select |
| cfg_wdata_i | input | 16 | Host write data |
| en_o | output | 1 | Enable bit |
| cur_ptr_o | output | 16 | Current descriptor pointer |
| done_flag_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Interrupt, flag AND interrupt enable |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 24 | Memory read address |
| mem_ready_i | input | 1 | Memory accepts the read and returns data |
| mem_rdata_i | input | 8 | Memory read byte |
| tx_req_i | input | 1 | Transmitter wants a byte |
| tx_ack_o | output | 1 | Byte on tx_data_o is taken this cycle |
| tx_data_o | output | 8 | Transmit byte |

## Verification
Some rules are checked on every cycle. A waiting memory request must hold its address. The current pointer may move only through a host write or while enabled. A falling enable bit that the host did not cause must come with the flag set, and the flag may rise only at the end of a run. Other behaviour can only be shown by the bench's scenarios, with the byte stream compared against a model that walks the same memory image. These include the field layout, the byte order across descriptors, skipping of empty descriptors, the wait for a request at the stop pointer and extending the chain during a run.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int ADDR_W = 24;
  localparam int PTR_W  = 16;
  localparam int PAGE_W = ADDR_W - PTR_W;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;
  localparam int CFG_AW = 3;
  localparam int CFG_DW = 16;

  // descriptor layout, byte offsets
  localparam int OFF_LINK = 0;
  localparam int OFF_BUF  = 2;
  localparam int OFF_CNT  = 5;
  localparam int DESC_RD  = 7;
  localparam int DIDX_W   = $clog2(DESC_RD + 1);

  localparam logic [CFG_AW-1:0] REG_PAGE = 3'd0;
  localparam logic [CFG_AW-1:0] REG_CUR  = 3'd1;
  localparam logic [CFG_AW-1:0] REG_END  = 3'd2;
  localparam logic [CFG_AW-1:0] REG_CTRL = 3'd3;
  localparam logic [CFG_AW-1:0] REG_STAT = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_DESC,
    ST_DATA
  } walk_state_e;
endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  input  logic              ptr_ld_i,
  input  logic [PTR_W-1:0]  ptr_nxt_i,
  input  logic              done_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [PTR_W-1:0]  cur_o,
  output logic [PTR_W-1:0]  end_o,
  output logic              en_o,
  output logic              ie_o,
  output logic              flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      cur_o  <= '0;
      end_o  <= '0;
      en_o   <= 1'b0;
      ie_o   <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (we_i && addr_i == REG_PAGE) page_o <= wdata_i[PAGE_W-1:0];
      if (we_i && addr_i == REG_END)  end_o  <= wdata_i[PTR_W-1:0];
      // engine load wins over a host write in the same cycle
      if (ptr_ld_i)                        cur_o <= ptr_nxt_i;
      else if (we_i && addr_i == REG_CUR)  cur_o <= wdata_i[PTR_W-1:0];
      if (we_i && addr_i == REG_CTRL) ie_o <= wdata_i[1];
      if (done_i)                          en_o <= 1'b0;
      else if (we_i && addr_i == REG_CTRL) en_o <= wdata_i[0];
      if (done_i)                                    flag_o <= 1'b1;
      else if (we_i && addr_i == REG_STAT && wdata_i[0]) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/txdma_txbuf.sv
module txdma_txbuf
  import txdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tx_req_i,
  output logic              full_o,
  output logic              tx_ack_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic [DATA_W-1:0] hold_q;

  assign tx_ack_o  = full_o & tx_req_i;
  assign tx_data_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      hold_q <= '0;
    end else if (push_i) begin
      full_o <= 1'b1;
      hold_q <= data_i;
    end else if (tx_ack_o) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/txdma_walker.sv
module txdma_walker
  import txdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PTR_W-1:0]  cur_i,
  input  logic [PTR_W-1:0]  end_i,
  input  logic              tx_req_i,
  input  logic              full_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              push_o,
  output logic              ptr_ld_o,
  output logic [PTR_W-1:0]  ptr_nxt_o,
  output logic              done_o
);
  localparam logic [DIDX_W-1:0] DIDX_LAST = DIDX_W'(DESC_RD - 1);

  walk_state_e       st_q, st_d;
  logic [DIDX_W-1:0] didx_q;
  logic [CNT_W-1:0]  bidx_q;
  logic [PTR_W-1:0]  link_q;
  logic [ADDR_W-1:0] buf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_now;
  logic              xfer;

  assign xfer    = mem_req_o & mem_ready_i;
  assign cnt_now = {mem_rdata_i, cnt_q[DATA_W-1:0]};
  assign ptr_nxt_o = link_q;

  always_comb begin
    st_d       = st_q;
    mem_req_o  = 1'b0;
    mem_addr_o = {page_i, cur_i} + ADDR_W'(didx_q);
    push_o     = 1'b0;
    ptr_ld_o   = 1'b0;
    done_o     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (en_i) st_d = ST_LOOK;
      ST_LOOK: begin
        if (cur_i == end_i) begin
          if (tx_req_i && !full_i) begin
            done_o = 1'b1;
            st_d   = ST_IDLE;
          end
        end else begin
          st_d = ST_DESC;
        end
      end
      ST_DESC: begin
        mem_req_o = 1'b1;
        if (mem_ready_i && didx_q == DIDX_LAST) begin
          if (cnt_now == '0) begin
            ptr_ld_o = 1'b1;
            st_d     = ST_LOOK;
          end else begin
            st_d = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        mem_addr_o = buf_q + ADDR_W'(bidx_q);
        mem_req_o  = !full_i;
        if (mem_ready_i && !full_i) begin
          push_o = 1'b1;
          if (bidx_q + 1'b1 == cnt_q) begin
            ptr_ld_o = 1'b1;
            st_d     = ST_LOOK;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!en_i) begin
      st_d      = ST_IDLE;
      mem_req_o = 1'b0;
      push_o    = 1'b0;
      ptr_ld_o  = 1'b0;
      done_o    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      didx_q <= '0;
      bidx_q <= '0;
      link_q <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_LOOK) begin
        didx_q <= '0;
        bidx_q <= '0;
      end
      if (st_q == ST_DESC && xfer) begin
        didx_q <= didx_q + 1'b1;
        unique case (int'(didx_q))
          OFF_LINK:     link_q[7:0]   <= mem_rdata_i;
          OFF_LINK + 1: link_q[15:8]  <= mem_rdata_i;
          OFF_BUF:      buf_q[7:0]    <= mem_rdata_i;
          OFF_BUF + 1:  buf_q[15:8]   <= mem_rdata_i;
          OFF_BUF + 2:  buf_q[23:16]  <= mem_rdata_i;
          OFF_CNT:      cnt_q[7:0]    <= mem_rdata_i;
          OFF_CNT + 1:  cnt_q[15:8]   <= mem_rdata_i;
          default: ;
        endcase
      end
      if (st_q == ST_DATA && xfer) bidx_q <= bidx_q + 1'b1;
    end
  end
endmodule

// File: rtl/txdma_chain.sv
module txdma_chain
  import txdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              en_o,
  output logic [PTR_W-1:0]  cur_ptr_o,
  output logic              done_flag_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              tx_req_i,
  output logic              tx_ack_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic [PAGE_W-1:0] page;
  logic [PTR_W-1:0]  end_ptr;
  logic [PTR_W-1:0]  ptr_nxt;
  logic              ie, ptr_ld, done, push, full;

  assign irq_o = done_flag_o & ie;

  txdma_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .ptr_ld_i  (ptr_ld),
    .ptr_nxt_i (ptr_nxt),
    .done_i    (done),
    .page_o    (page),
    .cur_o     (cur_ptr_o),
    .end_o     (end_ptr),
    .en_o      (en_o),
    .ie_o      (ie),
    .flag_o    (done_flag_o)
  );

  txdma_walker u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_o),
    .page_i      (page),
    .cur_i       (cur_ptr_o),
    .end_i       (end_ptr),
    .tx_req_i    (tx_req_i),
    .full_i      (full),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .push_o      (push),
    .ptr_ld_o    (ptr_ld),
    .ptr_nxt_o   (ptr_nxt),
    .done_o      (done)
  );

  txdma_txbuf u_txbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .data_i    (mem_rdata_i),
    .tx_req_i  (tx_req_i),
    .full_o    (full),
    .tx_ack_o  (tx_ack_o),
    .tx_data_o (tx_data_o)
  );
endmodule

// File: rtl/txdma_chain_chk.sv
module txdma_chain_chk
  import txdma_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic [CFG_DW-1:0] cfg_wdata_i,
  input logic              en_o,
  input logic [PTR_W-1:0]  cur_ptr_o,
  input logic              done_flag_o,
  input logic              irq_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              tx_req_i,
  input logic              tx_ack_o,
  input logic [DATA_W-1:0] tx_data_o
);
  logic host_cur_wr, host_ctrl_wr;
  assign host_cur_wr  = cfg_we_i && cfg_addr_i == REG_CUR;
  assign host_ctrl_wr = cfg_we_i && cfg_addr_i == REG_CTRL;

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> !en_o || (mem_req_o && $stable(mem_addr_o)));

  assert_ptr_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_ptr_o) && !$past(host_cur_wr) |-> $past(en_o));

  assert_stop_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o) && !$past(host_ctrl_wr) |-> done_flag_o);

  assert_flag_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_flag_o) |-> $fell(en_o));

  assert_ack_needs_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ack_o |-> tx_req_i);

  assert_quiet_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o && $past(!en_o) |-> !mem_req_o && !tx_ack_o ||
      (tx_ack_o && tx_req_i));
endmodule

bind txdma_chain txdma_chain_chk u_chk (.*);

// File: tb/tb_txdma_chain.sv
module tb_txdma_chain;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        en, done_flag, irq, mem_req, mem_ready, tx_req, tx_ack;
  logic [15:0] cur_ptr;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata, tx_data;

  localparam logic [7:0] PAGE = 8'h5A;

  logic [7:0] mem [0:4095];
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // memory answers only inside the programmed page
  assign mem_rdata = (mem_addr[23:16] == PAGE) ? mem[mem_addr[11:0]] : 8'hEE;

  txdma_chain dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .en_o(en), .cur_ptr_o(cur_ptr), .done_flag_o(done_flag),
    .irq_o(irq), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .tx_req_i(tx_req), .tx_ack_o(tx_ack), .tx_data_o(tx_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_desc(input logic [15:0] p, input logic [15:0] link,
                          input logic [15:0] boff, input logic [15:0] cnt);
    mem[p[11:0]]      = link[7:0];
    mem[p[11:0] + 1]  = link[15:8];
    mem[p[11:0] + 2]  = boff[7:0];
    mem[p[11:0] + 3]  = boff[15:8];
    mem[p[11:0] + 4]  = PAGE;
    mem[p[11:0] + 5]  = cnt[7:0];
    mem[p[11:0] + 6]  = cnt[15:8];
    mem[p[11:0] + 7]  = 8'hC3;
    for (int i = 0; i < int'(cnt); i++) mem[boff[11:0] + 12'(i)] = 8'($urandom);
  endtask

  // reference walk over the bench memory image
  task automatic model_walk(input logic [15:0] start, input logic [15:0] stop);
    logic [15:0] p;
    logic [15:0] boff, cnt;
    p = start;
    exp_q.delete();
    for (int k = 0; k < 64 && p != stop; k++) begin
      boff = {mem[p[11:0] + 3], mem[p[11:0] + 2]};
      cnt  = {mem[p[11:0] + 6], mem[p[11:0] + 5]};
      for (int i = 0; i < int'(cnt); i++) exp_q.push_back(mem[boff[11:0] + 12'(i)]);
      p = {mem[p[11:0] + 1], mem[p[11:0]]};
    end
  endtask

  // builds n descriptors, returns stop pointer; zero_at < 0 means no empty descriptor
  task automatic build(input int n, input int zero_at, input int maxc, output logic [15:0] stop);
    logic [15:0] p, nx, cnt;
    for (int k = 0; k < n; k++) begin
      p   = 16'h0010 + 16'(k * 24);
      nx  = 16'h0010 + 16'((k + 1) * 24);
      cnt = (k == zero_at) ? 16'd0 : 16'(1 + ($urandom % maxc));
      put_desc(p, nx, 16'h0400 + 16'(k * 64), cnt);
    end
    stop = 16'h0010 + 16'(n * 24);
  endtask

  task automatic run(input int req_pct, input int rdy_pct);
    int cyc;
    cyc = 0;
    while (en && cyc < 4000) begin
      @(negedge clk);
      tx_req    = ($urandom % 100) < req_pct;
      mem_ready = ($urandom % 100) < rdy_pct;
      #1;
      if (tx_ack) got_q.push_back(tx_data);
      cyc++;
    end
    @(negedge clk);
    tx_req = 1'b0;
    chk(cyc < 4000, "R7 run ended", cyc, 4000);
  endtask

  task automatic compare(input string tag);
    bit ok;
    ok = got_q.size() == exp_q.size();
    if (ok) foreach (exp_q[i]) if (got_q[i] != exp_q[i]) ok = 0;
    chk(ok, tag, got_q.size(), exp_q.size());
  endtask

  task automatic chain_test(input int n, input int zero_at, input int maxc, input bit ie,
                            input int req_pct, input int rdy_pct);
    logic [15:0] stop;
    build(n, zero_at, maxc, stop);
    model_walk(16'h0010, stop);
    got_q.delete();
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'h0010);
    wr(3'd2, stop);
    wr(3'd3, {14'd0, ie, 1'b1});
    run(req_pct, rdy_pct);
    compare("R3 R2 byte stream");
    chk(cur_ptr == stop, "R5 pointer at stop", cur_ptr, stop);
    chk(!en && done_flag, "R7 enable cleared flag set", {en, done_flag}, 2'b01);
    chk(irq == ie, "R9 irq follows enable", irq, ie);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] stop;
    void'($urandom(32'd4242));
    tx_req = 1'b0;
    mem_ready = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!en && !done_flag && !irq && cur_ptr == 16'h0, "R1 reset regs",
        {en, done_flag, irq, cur_ptr}, 0);
    chk(!mem_req && !tx_ack, "R1 reset outputs", {mem_req, tx_ack}, 0);

    wr(3'd0, {8'h00, PAGE});  // R10 page register

    // R2 R3 R5 R6 directed: counts 3, 0, 4
    put_desc(16'h0010, 16'h0028, 16'h0400, 16'd3);
    put_desc(16'h0028, 16'h0040, 16'h0440, 16'd0);
    put_desc(16'h0040, 16'h0058, 16'h0480, 16'd4);
    model_walk(16'h0010, 16'h0058);
    chk(exp_q.size() == 7, "R6 model skips empty", exp_q.size(), 7);
    got_q.delete();
    wr(3'd1, 16'h0010);
    wr(3'd2, 16'h0058);
    wr(3'd3, 16'h0003);
    run(100, 100);
    compare("R6 R3 directed stream");
    chk(cur_ptr == 16'h0058, "R5 pointer follows links", cur_ptr, 16'h0058);

    // R7 waits at stop pointer until a request arrives
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'h0100);
    wr(3'd2, 16'h0100);
    wr(3'd3, 16'h0001);
    begin
      bit quiet;
      quiet = 1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); #1;
        if (mem_req || !en) quiet = 0;
      end
      chk(quiet, "R7 no fetch at stop", quiet, 1);
    end
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0; #1;
    chk(!en && done_flag, "R7 request ends run", {en, done_flag}, 2'b01);
    chk(!irq, "R9 irq masked", irq, 0);
    wr(3'd3, 16'h0002);
    #1 chk(irq, "R9 irq enabled", irq, 1);
    wr(3'd4, 16'h0000);
    #1 chk(done_flag, "R9 write zero keeps flag", done_flag, 1);
    wr(3'd4, 16'h0001);
    #1 chk(!done_flag && !irq, "R9 write one clears", {done_flag, irq}, 0);

    // R8 extend the chain during a run
    build(4, -1, 6, stop);
    model_walk(16'h0010, stop);
    got_q.delete();
    wr(3'd1, 16'h0010);
    wr(3'd2, 16'h0028);
    mem_ready = 1'b1;
    tx_req = 1'b0;
    wr(3'd3, 16'h0001);
    repeat (20) @(negedge clk);
    wr(3'd2, stop);
    #1 chk(en, "R8 still running before extend", en, 1);
    run(60, 80);
    compare("R8 appended stream");
    chk(cur_ptr == stop, "R8 pointer at new stop", cur_ptr, stop);

    // random chains
    for (int t = 0; t < 20; t++) begin
      chain_test(1 + ($urandom % 5), ($urandom % 3 == 0) ? int'($urandom % 5) : -1,
                 12, 1'($urandom), 30 + int'($urandom % 70), 30 + int'($urandom % 70));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule